// File: doc/BRIEF.md
# Pipelined Column-Selector Bus

This block connects several bus masters to register columns spread over a large array of user logic. Masters raise a request; a round-robin arbiter accepts one of them per cycle and launches its address, direction and write data into a short pipeline. In the next stage each column's selector compares the address against the range it was given at start-up. In the stage after that the chosen column sees its enable, the shared address and the write data. Each selector passes on its column's read data only when it is selected, and all columns are OR-combined onto one read line. A registered read result comes back one stage later, tagged with the master that asked for it.

A selector that is hit always adds one wait cycle. The user logic in any column can extend the stall by holding its wait line. Any raised wait freezes the whole pipeline: no new grant is issued, and every stage register keeps its contents. The ranges are loaded through a small configuration port, one column per write, before traffic starts.

Top module: `pipe_sel_bus`

## Requirements
- R1: The arbiter asserts at most one bit of `gnt`, in the same cycle that it accepts a request. Priority is round-robin and starts after the master granted last, and master 0 has first priority after reset.
- R2: A read accepted in cycle T that needs no wait returns `rd_valid` in cycle T+3. Every wait cycle pushes that return one cycle later.
- R3: A write accepted in cycle T drives its column with `col_we` high from cycle T+2. It never produces `rd_valid`.
- R4: A column is chosen when lo <= address <= hi for the bounds loaded by `cfg_we` for index `cfg_col`. When ranges overlap, the lowest column index wins. After reset every range is empty (lo all ones, hi zero), and `col_en` is never more than one-hot.
- R5: Read data from columns that are not selected has no effect on `rd_data`.
- R6: An access that hits a column always spends at least two cycles in the column stage (one mandatory wait).
- R7: While the selected column holds `col_wait`, the access stays in the column stage.
- R8: A `col_wait` from any column, selected or not, stalls the pipeline while an access is in the column stage.
- R9: An access that hits no column adds no wait of its own, and a read of it returns all-zero data.
- R10: During a stall no grant is issued, and `col_en`, `col_we`, `col_addr` and `col_wdata` hold their values.
- R11: `rd_mst` gives the index of the master whose read is returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | NM | Request per master |
| m_we | input | NM | Write flag per master |
| m_addr | input | NM*AW | Address per master, packed |
| m_wdata | input | NM*DW | Write data per master, packed |
| gnt | output | NM | Request accepted this cycle |
| cfg_we | input | 1 | Load one column's range |
| cfg_col | input | CW | Column to load |
| cfg_lo | input | AW | Lower bound, inclusive |
| cfg_hi | input | AW | Upper bound, inclusive |
| col_en | output | NC | Column enable, one-hot |
| col_we | output | 1 | Column access is a write |
| col_addr | output | AW | Address to the columns |
| col_wdata | output | DW | Write data to the columns |
| col_rdata | input | NC*DW | Read data from each column, packed |
| col_wait | input | NC | Wait request from each column |
| rd_valid | output | 1 | Read result valid |
| rd_mst | output | MW | Master of the returned read |
| rd_data | output | DW | Returned read data |

## Verification
The assertions check on every cycle that grants and column enables stay one-hot, that a stall blocks grants and freezes the column-side outputs, that a first hit cycle never returns data, and that a read with no enabled column returns zero. Only the bench's scenarios can show round-robin fairness among six masters, the exact latency of each access type under mandatory, extended and foreign waits, range priority on overlap, and read data that matches earlier writes while unselected columns drive noise.

// File: rtl/psb_pkg.sv
package psb_pkg;
  localparam int PSB_MASTERS = 6;
  localparam int PSB_COLS    = 4;
  localparam int PSB_AW      = 8;
  localparam int PSB_DW      = 16;
endpackage

// File: rtl/psb_arb.sv
module psb_arb #(
  parameter int N  = 6,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  input  logic          hold,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gnt_idx
);
  logic [IW-1:0] last;

  always_comb begin
    int idx;
    logic found;
    gnt     = '0;
    gnt_idx = '0;
    found   = 1'b0;
    for (int k = 1; k <= N; k++) begin
      idx = (int'(last) + k) % N;
      if (!found && !hold && req[idx]) begin
        gnt[idx] = 1'b1;
        gnt_idx  = IW'(idx);
        found    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       last <= IW'(N - 1);
    else if (|gnt) last <= gnt_idx;
  end
endmodule

// File: rtl/psb_sel.sv
module psb_sel #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld,
  input  logic [AW-1:0] lo_in,
  input  logic [AW-1:0] hi_in,
  input  logic [AW-1:0] addr,
  output logic          hit,
  input  logic          en,
  input  logic [DW-1:0] rd_in,
  output logic [DW-1:0] rd_out
);
  logic [AW-1:0] lo, hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo <= '1;
      hi <= '0;
    end else if (ld) begin
      lo <= lo_in;
      hi <= hi_in;
    end
  end

  assign hit    = (addr >= lo) && (addr <= hi);
  assign rd_out = rd_in & {DW{en}};
endmodule

// File: rtl/pipe_sel_bus.sv
module pipe_sel_bus
  import psb_pkg::*;
#(
  parameter int NM = PSB_MASTERS,
  parameter int NC = PSB_COLS,
  parameter int AW = PSB_AW,
  parameter int DW = PSB_DW,
  localparam int MW = (NM > 1) ? $clog2(NM) : 1,
  localparam int CW = (NC > 1) ? $clog2(NC) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NM-1:0]    req,
  input  logic [NM-1:0]    m_we,
  input  logic [NM*AW-1:0] m_addr,
  input  logic [NM*DW-1:0] m_wdata,
  output logic [NM-1:0]    gnt,
  input  logic             cfg_we,
  input  logic [CW-1:0]    cfg_col,
  input  logic [AW-1:0]    cfg_lo,
  input  logic [AW-1:0]    cfg_hi,
  output logic [NC-1:0]    col_en,
  output logic             col_we,
  output logic [AW-1:0]    col_addr,
  output logic [DW-1:0]    col_wdata,
  input  logic [NC*DW-1:0] col_rdata,
  input  logic [NC-1:0]    col_wait,
  output logic             rd_valid,
  output logic [MW-1:0]    rd_mst,
  output logic [DW-1:0]    rd_data
);
  // stage 1: launched transaction
  logic          s1_v, s1_we;
  logic [MW-1:0] s1_mst;
  logic [AW-1:0] s1_addr;
  logic [DW-1:0] s1_wd;
  // stage 2: decoded transaction at the columns
  logic          s2_v, s2_we, s2_first;
  logic [MW-1:0] s2_mst;
  logic [AW-1:0] s2_addr;
  logic [DW-1:0] s2_wd;
  logic [NC-1:0] s2_sel;

  logic          stall;
  logic [MW-1:0] g_idx;
  logic          g_we;
  logic [AW-1:0] g_addr;
  logic [DW-1:0] g_wd;
  logic [NC-1:0] hit, pick;
  logic [DW-1:0] rd_part [NC];
  logic [DW-1:0] rd_or;

  assign stall = s2_v & (((|s2_sel) & s2_first) | (|col_wait));

  psb_arb #(.N(NM), .IW(MW)) u_arb (
    .clk(clk), .rst(rst), .req(req), .hold(stall), .gnt(gnt), .gnt_idx(g_idx)
  );

  always_comb begin
    g_we   = 1'b0;
    g_addr = '0;
    g_wd   = '0;
    for (int m = 0; m < NM; m++) begin
      if (gnt[m]) begin
        g_we   = m_we[m];
        g_addr = m_addr[m*AW +: AW];
        g_wd   = m_wdata[m*DW +: DW];
      end
    end
  end

  for (genvar c = 0; c < NC; c++) begin : g_col
    psb_sel #(.AW(AW), .DW(DW)) u_sel (
      .clk(clk), .rst(rst),
      .ld(cfg_we && (cfg_col == CW'(c))),
      .lo_in(cfg_lo), .hi_in(cfg_hi),
      .addr(s1_addr), .hit(hit[c]),
      .en(s2_sel[c]),
      .rd_in(col_rdata[c*DW +: DW]),
      .rd_out(rd_part[c])
    );
  end

  // lowest-index hit wins
  always_comb begin
    logic taken;
    pick  = '0;
    taken = 1'b0;
    for (int c = 0; c < NC; c++) begin
      if (hit[c] && !taken) begin
        pick[c] = 1'b1;
        taken   = 1'b1;
      end
    end
  end

  always_comb begin
    rd_or = '0;
    for (int c = 0; c < NC; c++) rd_or = rd_or | rd_part[c];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v <= 1'b0; s1_we <= 1'b0; s1_mst <= '0; s1_addr <= '0; s1_wd <= '0;
      s2_v <= 1'b0; s2_we <= 1'b0; s2_mst <= '0; s2_addr <= '0; s2_wd <= '0;
      s2_sel <= '0; s2_first <= 1'b0;
      rd_valid <= 1'b0; rd_mst <= '0; rd_data <= '0;
    end else if (!stall) begin
      s1_v     <= |gnt;
      s1_we    <= g_we;
      s1_mst   <= g_idx;
      s1_addr  <= g_addr;
      s1_wd    <= g_wd;
      s2_v     <= s1_v;
      s2_we    <= s1_we;
      s2_mst   <= s1_mst;
      s2_addr  <= s1_addr;
      s2_wd    <= s1_wd;
      s2_sel   <= s1_v ? pick : '0;
      s2_first <= 1'b1;
      rd_valid <= s2_v & ~s2_we;
      rd_mst   <= s2_mst;
      rd_data  <= rd_or;
    end else begin
      s2_first <= 1'b0;
      rd_valid <= 1'b0;
    end
  end

  assign col_en    = s2_sel & {NC{s2_v}};
  assign col_we    = s2_we;
  assign col_addr  = s2_addr;
  assign col_wdata = s2_wd;
endmodule

// File: rtl/psb_chk.sv
module psb_chk #(
  parameter int NM = 6,
  parameter int NC = 4,
  parameter int AW = 8,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic [NM-1:0] gnt,
  input logic [NC-1:0] col_en,
  input logic          col_we,
  input logic [AW-1:0] col_addr,
  input logic [DW-1:0] col_wdata,
  input logic [NC-1:0] col_wait,
  input logic          rd_valid,
  input logic [DW-1:0] rd_data,
  input logic          s2_v,
  input logic          s2_first,
  input logic          stall
);
  assert_gnt_onehot_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt));

  assert_col_onehot_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(col_en));

  assert_no_grant_stall_R10: assert property (@(posedge clk) disable iff (rst)
    stall |-> (gnt == '0));

  assert_hold_stall_R10: assert property (@(posedge clk) disable iff (rst)
    stall |=> ($stable(col_addr) && $stable(col_wdata) && $stable(col_we) && $stable(col_en)));

  assert_first_hit_waits_R6: assert property (@(posedge clk) disable iff (rst)
    ((|col_en) && s2_first) |=> (!rd_valid && $stable(col_en)));

  assert_foreign_wait_R8: assert property (@(posedge clk) disable iff (rst)
    (s2_v && (|col_wait)) |=> !rd_valid);

  assert_miss_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && ($past(col_en) == '0)) |-> (rd_data == '0));
endmodule

bind pipe_sel_bus psb_chk #(.NM(NM), .NC(NC), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .gnt(gnt), .col_en(col_en), .col_we(col_we),
  .col_addr(col_addr), .col_wdata(col_wdata), .col_wait(col_wait),
  .rd_valid(rd_valid), .rd_data(rd_data), .s2_v(s2_v), .s2_first(s2_first),
  .stall(stall)
);

// File: tb/tb_pipe_sel_bus.sv
module tb_pipe_sel_bus;
  timeunit 1ns; timeprecision 100ps;
  localparam int NM = 6, NC = 4, AW = 8, DW = 16, MW = 3, CW = 2, QD = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic [NM-1:0] req = '0, m_we = '0, gnt;
  logic [NM*AW-1:0] m_addr = '0;
  logic [NM*DW-1:0] m_wdata = '0;
  logic cfg_we = 1'b0;
  logic [CW-1:0] cfg_col = '0;
  logic [AW-1:0] cfg_lo = '0, cfg_hi = '0;
  logic [NC-1:0] col_en, col_wait = '0;
  logic col_we, rd_valid;
  logic [AW-1:0] col_addr;
  logic [DW-1:0] col_wdata, rd_data;
  logic [NC*DW-1:0] col_rdata = '0;
  logic [MW-1:0] rd_mst;

  always #2.5 clk = ~clk;

  pipe_sel_bus #(.NM(NM), .NC(NC), .AW(AW), .DW(DW)) dut (.*);

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit finished = 0;

  // per-master operation queues
  int q_n[NM], q_h[NM];
  bit q_we[NM][QD];
  int q_ad[NM][QD], q_wd[NM][QD], q_xw[NM][QD], q_wc[NM][QD];

  // reference model state
  int mp;
  bit m1v, m1we; int m1mst, m1addr, m1wd, m1xw, m1wc;
  bit m2v, m2we, m2first; int m2mst, m2addr, m2wd, m2sel, wl, wc;
  bit rv; int rdat, rmst;
  int mlo[NC], mhi[NC];
  logic [DW-1:0] mem[NC][64];
  int t_g, t_r, t_e, t_rdat; bit e_we;

  task automatic chk(bit ok, string tag, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  function automatic int decode(int a);
    for (int c = 0; c < NC; c++) if (a >= mlo[c] && a <= mhi[c]) return c;
    return -1;
  endfunction

  task automatic push(int m, bit we, int a, int d, int xw, int w);
    q_we[m][q_n[m]] = we; q_ad[m][q_n[m]] = a; q_wd[m][q_n[m]] = d;
    q_xw[m][q_n[m]] = xw; q_wc[m][q_n[m]] = w; q_n[m]++;
  endtask

  task automatic model_reset();
    mp = NM - 1; m1v = 0; m2v = 0; m2first = 0; rv = 0; wl = 0; wc = -1; m2sel = -1;
    for (int c = 0; c < NC; c++) begin mlo[c] = 255; mhi[c] = 0; end
  endtask

  task automatic step();
    logic [NC-1:0] cw, een;
    logic [NM-1:0] eg;
    bit st; int gm, dsel;
    @(negedge clk);
    for (int m = 0; m < NM; m++) begin
      req[m] = (q_h[m] < q_n[m]);
      if (req[m]) begin
        m_we[m] = q_we[m][q_h[m]];
        m_addr[m*AW +: AW] = AW'(q_ad[m][q_h[m]]);
        m_wdata[m*DW +: DW] = DW'(q_wd[m][q_h[m]]);
      end
    end
    cw = '0;
    if (m2v && wl > 0 && wc >= 0) cw[wc] = 1'b1;
    col_wait = cw;
    for (int c = 0; c < NC; c++) col_rdata[c*DW +: DW] = mem[c][col_addr[5:0]];
    #1;
    st = m2v && ((m2sel >= 0 && m2first) || cw != 0);
    eg = '0; gm = -1;
    if (!st) for (int k = 1; k <= NM; k++) if (gm < 0 && req[(mp + k) % NM]) gm = (mp + k) % NM;
    if (gm >= 0) eg[gm] = 1'b1;
    een = (m2v && m2sel >= 0) ? NC'(1 << m2sel) : '0;
    if (!rst) begin
      chk(gnt == eg, "R1 grant", gnt, eg);
      chk(col_en == een, "R4 column enable", col_en, een);
      if (m2v) begin
        chk(col_we == m2we, "R3 column write flag", col_we, m2we);
        chk(col_addr == AW'(m2addr), "R10 column address", col_addr, m2addr);
        if (m2we) chk(col_wdata == DW'(m2wd), "R10 column write data", col_wdata, m2wd);
      end
      chk(rd_valid == rv, "R2 read valid", rd_valid, rv);
      if (rv) begin
        chk(rd_data == DW'(rdat), "R5 read data", rd_data, rdat);
        chk(rd_mst == MW'(rmst), "R11 read master", rd_mst, rmst);
      end
    end
    if (gm >= 0) t_g = cyc;
    if (rd_valid) begin t_r = cyc; t_rdat = int'(rd_data); end
    if (col_en != 0 && t_e < 0) begin t_e = cyc; e_we = col_we; end
    @(posedge clk);
    if (rst) model_reset();
    else begin
      if (!st) begin
        rv = m2v && !m2we; rmst = m2mst;
        rdat = (m2sel >= 0) ? int'(mem[m2sel][m2addr % 64]) : 0;
        if (m2v && m2we && m2sel >= 0) mem[m2sel][m2addr % 64] = DW'(m2wd);
        dsel = decode(m1addr);
        m2v = m1v; m2we = m1we; m2mst = m1mst; m2addr = m1addr; m2wd = m1wd;
        m2sel = m1v ? dsel : -1; m2first = 1; wl = m1xw;
        wc = (m1wc < 0) ? m2sel : m1wc;
        m1v = (gm >= 0);
        if (gm >= 0) begin
          m1we = q_we[gm][q_h[gm]]; m1mst = gm; m1addr = q_ad[gm][q_h[gm]];
          m1wd = q_wd[gm][q_h[gm]]; m1xw = q_xw[gm][q_h[gm]]; m1wc = q_wc[gm][q_h[gm]];
          q_h[gm]++; mp = gm;
        end
      end else begin
        rv = 0; m2first = 0;
        if (wl > 0) wl--;
      end
      if (cfg_we) begin mlo[cfg_col] = int'(cfg_lo); mhi[cfg_col] = int'(cfg_hi); end
    end
    cyc++;
  endtask

  function automatic bit busy();
    for (int m = 0; m < NM; m++) if (q_h[m] < q_n[m]) return 1;
    return m1v || m2v || rv;
  endfunction

  task automatic drain(output bit ok);
    int n = 0;
    ok = 1;
    while (busy()) begin
      step(); n++;
      if (n > 400) begin ok = 0; break; end
    end
  endtask

  task automatic single(bit we, int a, int xw, int w, int lat, string tag, output bit ok);
    t_g = -1; t_r = -1; t_e = -1;
    push(2, we, a, 16'h7E7E, xw, w);
    drain(ok);
    if (we) begin
      chk((t_e - t_g == 2) && e_we, tag, t_e - t_g, 2);
      chk(t_r < 0, tag, t_r, -1);
    end else chk(t_r - t_g == lat, tag, t_r - t_g, lat);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    bit ok;
    for (int c = 0; c < NC; c++)
      for (int a = 0; a < 64; a++) mem[c][a] = DW'(16'hA000 | (c << 8) | a);
    for (int m = 0; m < NM; m++) begin q_n[m] = 0; q_h[m] = 0; end
    model_reset();
    repeat (3) step();
    rst = 1'b0;
    @(negedge clk); #1;
    chk(gnt == '0 && col_en == '0 && rd_valid == 1'b0, "R1 reset idle", {gnt, col_en, rd_valid}, 0);

    // R4: load ranges; columns 2 and 3 overlap at 0x30..0x3F
    cfg_we = 1; cfg_col = 0; cfg_lo = 8'h00; cfg_hi = 8'h0F; step();
    cfg_col = 1; cfg_lo = 8'h10; cfg_hi = 8'h1F; step();
    cfg_col = 2; cfg_lo = 8'h20; cfg_hi = 8'h3F; step();
    cfg_col = 3; cfg_lo = 8'h30; cfg_hi = 8'h4F; step();
    cfg_we = 0; step();

    // serial latency cases
    single(0, 8'h80, 0, -1, 3, "R9 miss read latency", ok);
    chk(t_rdat == 0, "R9 miss read data", t_rdat, 0);
    single(0, 8'h07, 0, -1, 4, "R6 hit read latency", ok);
    single(0, 8'h12, 3, -1, 6, "R7 extended wait latency", ok);
    single(0, 8'h80, 2, 2, 5, "R8 unselected column wait latency", ok);
    single(1, 8'h03, 0, -1, 0, "R3 write timing", ok);
    single(0, 8'h35, 0, -1, 4, "R4 overlap read latency", ok);

    // concurrent traffic from all masters
    push(0, 1, 8'h05, 16'h1111, 0, -1); push(0, 0, 8'h05, 0, 0, -1); push(0, 0, 8'h90, 0, 0, -1);
    push(1, 1, 8'h12, 16'h2222, 2, -1); push(1, 0, 8'h12, 0, 0, -1);
    push(2, 0, 8'h35, 0, 0, -1); push(2, 0, 8'h45, 0, 1, -1);
    push(3, 0, 8'h80, 0, 2, 1); push(3, 1, 8'h4F, 16'h3333, 0, -1);
    push(4, 0, 8'h07, 0, 1, 3); push(4, 0, 8'h4F, 0, 0, -1);
    push(5, 1, 8'h3F, 16'h5555, 0, -1); push(5, 0, 8'h3F, 0, 0, -1);
    drain(ok);
    if (!ok) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R2: actual hung expected drained");
    end
    repeat (3) step();
    summary();
  end
endmodule